// File: doc/BRIEF.md
# Adaptive Key Reference Tracker

This block keeps an 8-bit baseline ("reference") for every key of a scanned capacitive key array. Each key's sample arrives as a single-cycle beat carrying the key index, its measured signal, whether the key is currently in detection, and whether the signal lies above its positive threshold. The key's own tuning values come with the same beat. The block updates that key's stored reference and returns it with two window-edge flags.

While a key is not detecting, its reference creeps toward the signal one count at a time. The number of samples needed for each step is set separately for the upward and the downward direction. During a detection the creep stops. If a detection lasts too long, or the signal sits above the positive threshold for too long, the reference jumps straight to the signal. Flags mark a reference near the top or the bottom of the 8-bit range. Nothing in the block acts on these flags.

State for all keys lives in one memory with a registered read. A sample for the same key may follow on the next cycle; a forwarding path covers that case. A seed input loads the reference from the signal; this is where an external full calibration hands over.

Top module: `key_ref_tracker`

## Requirements
- R1: Each accepted sample (in_valid high) produces exactly one result two clock cycles later, with out_valid high and out_key equal to the sample's key index. No result appears for idle cycles.
- R2: A sample with in_cal high sets the key's reference to in_sig and clears its drift and both timeout counts. The drift direction restarts as upward.
- R3: With no detection, no snap and in_sig above the reference, the reference rises by one on the in_up_rate-th consecutive upward sample. An up rate of 0 disables upward drift.
- R4: With no detection, no snap and in_sig below the reference, the reference falls by one on the in_dn_rate-th consecutive downward sample. The down rate is independent of the up rate, and a down rate of 0 disables downward drift.
- R5: While in_detect is high, drift does not move the reference, and the drift count restarts from zero.
- R6: When in_detect is high for in_neg_dly consecutive samples of a key, the reference is set to in_sig on the last of them. A non-detect sample restarts the count, a delay of 0 disables the snap, and the count saturates at its maximum.
- R7: When in_pos_hi is high without detection for in_pos_dly consecutive samples of a key, the reference is set to in_sig on the last of them. Any other sample restarts the count, a delay of 0 disables the snap, and a snap sample does not also drift.
- R8: out_err_hi is 1 exactly when the returned reference exceeds 191. out_err_lo is 1 exactly when it is below 64. Neither flag changes the reference.
- R9: Every key keeps its own state. Interleaved samples, including back-to-back samples of one key, give the same results as if each key were processed alone.
- R10: The drift count restarts when the signal equals the reference or when the drift direction reverses. After a reversal, the sample that reverses counts as the first of the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample beat present |
| in_key | input | KEY_W | Key index of the sample |
| in_sig | input | SIG_W | Measured signal |
| in_detect | input | 1 | Key is in detection |
| in_pos_hi | input | 1 | Signal above positive threshold |
| in_cal | input | 1 | Seed reference from signal |
| in_up_rate | input | RATE_W | Samples per upward drift step, 0 = off |
| in_dn_rate | input | RATE_W | Samples per downward drift step, 0 = off |
| in_neg_dly | input | DLY_W | Detection length before snap, 0 = off |
| in_pos_dly | input | DLY_W | Positive excursion length before snap, 0 = off |
| out_valid | output | 1 | Result present |
| out_key | output | KEY_W | Key index of the result |
| out_ref | output | SIG_W | Updated reference |
| out_err_hi | output | 1 | Reference above 191 |
| out_err_lo | output | 1 | Reference below 64 |

## Verification
The bench builds the tracker with four keys, a 3-bit drift counter and 4-bit timeout counters. With only four keys, random traffic often sends the same key on back-to-back cycles, which exercises the forwarding path behind R9. The narrow counters let a long detection with the snap disabled reach counter saturation within a few samples. Directed runs cover drift steps, direction reversal, both snaps and the exact flag edges at 64 and 191/192.

// File: rtl/key_ref_pkg.sv
package key_ref_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } drift_dir_e;
endpackage

// File: rtl/key_ref_mem.sv
module key_ref_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/key_ref_update.sv
module key_ref_update
  import key_ref_pkg::*;
#(
  parameter int SIG_W  = 8,
  parameter int RATE_W = 4,
  parameter int DLY_W  = 8
) (
  input  logic [SIG_W-1:0]  ref_q,
  input  logic              dir_q,
  input  logic [RATE_W-1:0] dc_q,
  input  logic [DLY_W-1:0]  nc_q,
  input  logic [DLY_W-1:0]  pc_q,
  input  logic [SIG_W-1:0]  sig,
  input  logic              detect,
  input  logic              pos_hi,
  input  logic              cal,
  input  logic [RATE_W-1:0] up_rate,
  input  logic [RATE_W-1:0] dn_rate,
  input  logic [DLY_W-1:0]  neg_dly,
  input  logic [DLY_W-1:0]  pos_dly,
  output logic [SIG_W-1:0]  ref_n,
  output logic              dir_n,
  output logic [RATE_W-1:0] dc_n,
  output logic [DLY_W-1:0]  nc_n,
  output logic [DLY_W-1:0]  pc_n
);
  localparam logic [RATE_W-1:0] DC_MAX  = {RATE_W{1'b1}};
  localparam logic [DLY_W-1:0]  DLY_MAX = {DLY_W{1'b1}};

  logic [DLY_W-1:0]  nc_inc, pc_inc;
  logic [RATE_W-1:0] dc_same, dc_step;
  logic [RATE_W-1:0] rate_sel;
  logic              sig_above, sig_below, snap;
  drift_dir_e        want_dir;

  assign nc_inc    = (nc_q == DLY_MAX) ? nc_q : nc_q + 1'b1;
  assign pc_inc    = (pc_q == DLY_MAX) ? pc_q : pc_q + 1'b1;
  assign dc_same   = (dc_q == DC_MAX) ? dc_q : dc_q + 1'b1;
  assign sig_above = sig > ref_q;
  assign sig_below = sig < ref_q;
  assign want_dir  = sig_above ? DIR_UP : DIR_DN;
  assign dc_step   = (dir_q == want_dir) ? dc_same : RATE_W'(1);
  assign rate_sel  = sig_above ? up_rate : dn_rate;

  always_comb begin
    ref_n = ref_q;
    dir_n = dir_q;
    dc_n  = dc_q;
    nc_n  = '0;
    pc_n  = '0;
    snap  = 1'b0;
    if (cal) begin
      ref_n = sig;
      dir_n = DIR_UP;
      dc_n  = '0;
    end else if (detect) begin
      dc_n = '0;
      nc_n = nc_inc;
      if ((neg_dly != '0) && (nc_inc >= neg_dly)) begin
        ref_n = sig;
        nc_n  = '0;
      end
    end else begin
      if (pos_hi) begin
        pc_n = pc_inc;
        if ((pos_dly != '0) && (pc_inc >= pos_dly)) begin
          ref_n = sig;
          pc_n  = '0;
          snap  = 1'b1;
        end
      end
      if (snap) begin
        dc_n = '0;
      end else if (sig_above || sig_below) begin
        dir_n = want_dir;
        if (rate_sel == '0) begin
          dc_n = '0;
        end else if (dc_step >= rate_sel) begin
          dc_n  = '0;
          ref_n = sig_above ? ref_q + 1'b1 : ref_q - 1'b1;
        end else begin
          dc_n = dc_step;
        end
      end else begin
        dc_n = '0;
      end
    end
  end
endmodule

// File: rtl/key_ref_bounds.sv
module key_ref_bounds #(
  parameter int SIG_W  = 8,
  parameter int HI_LIM = 191,
  parameter int LO_LIM = 64
) (
  input  logic [SIG_W-1:0] ref_v,
  output logic             err_hi,
  output logic             err_lo
);
  localparam logic [SIG_W-1:0] HI_V = SIG_W'(HI_LIM);
  localparam logic [SIG_W-1:0] LO_V = SIG_W'(LO_LIM);

  assign err_hi = ref_v > HI_V;
  assign err_lo = ref_v < LO_V;
endmodule

// File: rtl/key_ref_tracker.sv
module key_ref_tracker #(
  parameter int NUM_KEYS = 64,
  parameter int SIG_W    = 8,
  parameter int RATE_W   = 4,
  parameter int DLY_W    = 8,
  parameter int HI_LIM   = 191,
  parameter int LO_LIM   = 64,
  localparam int KEY_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_detect,
  input  logic              in_pos_hi,
  input  logic              in_cal,
  input  logic [RATE_W-1:0] in_up_rate,
  input  logic [RATE_W-1:0] in_dn_rate,
  input  logic [DLY_W-1:0]  in_neg_dly,
  input  logic [DLY_W-1:0]  in_pos_dly,
  output logic              out_valid,
  output logic [KEY_W-1:0]  out_key,
  output logic [SIG_W-1:0]  out_ref,
  output logic              out_err_hi,
  output logic              out_err_lo
);
  localparam int ST_W = SIG_W + 1 + RATE_W + 2 * DLY_W;

  // stage 1 sample registers
  logic              s1_valid, s1_fwd;
  logic [KEY_W-1:0]  s1_key;
  logic [SIG_W-1:0]  s1_sig;
  logic              s1_det, s1_pos, s1_cal;
  logic [RATE_W-1:0] s1_up, s1_dn;
  logic [DLY_W-1:0]  s1_nd, s1_pd;
  logic [ST_W-1:0]   s1_fwd_st;

  logic [ST_W-1:0]   mem_q, cur_st, nxt_st;
  logic [SIG_W-1:0]  ref_q, ref_n;
  logic              dir_q, dir_n;
  logic [RATE_W-1:0] dc_q, dc_n;
  logic [DLY_W-1:0]  nc_q, nc_n, pc_q, pc_n;
  logic              flag_hi, flag_lo;

  key_ref_mem #(.DEPTH(NUM_KEYS), .WIDTH(ST_W)) u_mem (
    .clk   (clk),
    .we    (s1_valid),
    .waddr (s1_key),
    .wdata (nxt_st),
    .re    (in_valid),
    .raddr (in_key),
    .rdata (mem_q)
  );

  assign cur_st = s1_fwd ? s1_fwd_st : mem_q;
  assign {ref_q, dir_q, dc_q, nc_q, pc_q} = cur_st;
  assign nxt_st = {ref_n, dir_n, dc_n, nc_n, pc_n};

  key_ref_update #(.SIG_W(SIG_W), .RATE_W(RATE_W), .DLY_W(DLY_W)) u_upd (
    .ref_q   (ref_q),
    .dir_q   (dir_q),
    .dc_q    (dc_q),
    .nc_q    (nc_q),
    .pc_q    (pc_q),
    .sig     (s1_sig),
    .detect  (s1_det),
    .pos_hi  (s1_pos),
    .cal     (s1_cal),
    .up_rate (s1_up),
    .dn_rate (s1_dn),
    .neg_dly (s1_nd),
    .pos_dly (s1_pd),
    .ref_n   (ref_n),
    .dir_n   (dir_n),
    .dc_n    (dc_n),
    .nc_n    (nc_n),
    .pc_n    (pc_n)
  );

  key_ref_bounds #(.SIG_W(SIG_W), .HI_LIM(HI_LIM), .LO_LIM(LO_LIM)) u_bnd (
    .ref_v  (ref_n),
    .err_hi (flag_hi),
    .err_lo (flag_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_fwd     <= 1'b0;
      out_valid  <= 1'b0;
      out_key    <= '0;
      out_ref    <= '0;
      out_err_hi <= 1'b0;
      out_err_lo <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_fwd    <= in_valid && s1_valid && (in_key == s1_key);
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_key    <= s1_key;
        out_ref    <= ref_n;
        out_err_hi <= flag_hi;
        out_err_lo <= flag_lo;
      end
    end
  end

  always_ff @(posedge clk) begin
    s1_key    <= in_key;
    s1_sig    <= in_sig;
    s1_det    <= in_detect;
    s1_pos    <= in_pos_hi;
    s1_cal    <= in_cal;
    s1_up     <= in_up_rate;
    s1_dn     <= in_dn_rate;
    s1_nd     <= in_neg_dly;
    s1_pd     <= in_pos_dly;
    s1_fwd_st <= nxt_st;
  end
endmodule

// File: rtl/key_ref_tracker_chk.sv
module key_ref_tracker_chk #(
  parameter int KEY_W  = 6,
  parameter int SIG_W  = 8,
  parameter int DLY_W  = 8,
  parameter int HI_LIM = 191,
  parameter int LO_LIM = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [KEY_W-1:0] in_key,
  input logic [SIG_W-1:0] in_sig,
  input logic             in_detect,
  input logic             in_pos_hi,
  input logic             in_cal,
  input logic [DLY_W-1:0] in_neg_dly,
  input logic [DLY_W-1:0] in_pos_dly,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_key,
  input logic [SIG_W-1:0] out_ref,
  input logic             out_err_hi,
  input logic             out_err_lo
);
  a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_valid && out_key == $past(in_key, 2)));

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  a_r2_seed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cal) |-> ##2 (out_ref == $past(in_sig, 2)));

  a_r6_neg_snap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_cal && in_detect && in_neg_dly == DLY_W'(1))
      |-> ##2 (out_ref == $past(in_sig, 2)));

  a_r7_pos_snap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_cal && !in_detect && in_pos_hi && in_pos_dly == DLY_W'(1))
      |-> ##2 (out_ref == $past(in_sig, 2)));

  a_r8_flag_hi: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err_hi == (out_ref > SIG_W'(HI_LIM))));

  a_r8_flag_lo: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err_lo == (out_ref < SIG_W'(LO_LIM))));
endmodule

bind key_ref_tracker key_ref_tracker_chk #(
  .KEY_W(KEY_W), .SIG_W(SIG_W), .DLY_W(DLY_W), .HI_LIM(HI_LIM), .LO_LIM(LO_LIM)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key), .in_sig(in_sig),
  .in_detect(in_detect), .in_pos_hi(in_pos_hi), .in_cal(in_cal),
  .in_neg_dly(in_neg_dly), .in_pos_dly(in_pos_dly), .out_valid(out_valid),
  .out_key(out_key), .out_ref(out_ref), .out_err_hi(out_err_hi), .out_err_lo(out_err_lo)
);

// File: tb/test_key_ref_tracker.sv
`timescale 1ns/1ps
module test_key_ref_tracker;
  localparam int NK = 4, SW = 8, RW = 3, DW = 4, KW = 2;
  localparam int CMAX = 7, DMAX = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_detect = 1'b0, in_pos_hi = 1'b0, in_cal = 1'b0;
  logic [KW-1:0] in_key = '0;
  logic [SW-1:0] in_sig = '0;
  logic [RW-1:0] in_up_rate = '0, in_dn_rate = '0;
  logic [DW-1:0] in_neg_dly = '0, in_pos_dly = '0;
  logic out_valid, out_err_hi, out_err_lo;
  logic [KW-1:0] out_key;
  logic [SW-1:0] out_ref;

  int checks = 0, errors = 0;

  typedef struct { int key; int rv; bit hi; bit lo; } exp_t;
  exp_t  expq[$];
  string tagq[$];

  int mref [NK], mdc [NK], mnc [NK], mpc [NK];
  bit mdir [NK];

  always #2.5 clk = ~clk;

  key_ref_tracker #(.NUM_KEYS(NK), .SIG_W(SW), .RATE_W(RW), .DLY_W(DW)) i_key_ref_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key), .in_sig(in_sig),
    .in_detect(in_detect), .in_pos_hi(in_pos_hi), .in_cal(in_cal),
    .in_up_rate(in_up_rate), .in_dn_rate(in_dn_rate), .in_neg_dly(in_neg_dly),
    .in_pos_dly(in_pos_dly), .out_valid(out_valid), .out_key(out_key),
    .out_ref(out_ref), .out_err_hi(out_err_hi), .out_err_lo(out_err_lo)
  );

  // driver: expected value from the requirements, then the pin beat
  task automatic send(int k, int s, bit det, bit pos, bit cal,
                      int up, int dn, int nd, int pd, string tag);
    int r = mref[k], dc = mdc[k], nc = mnc[k], pc = mpc[k], c;
    bit dir = mdir[k], snap = 0;
    exp_t e;
    if (cal) begin                              // R2
      r = s; dc = 0; dir = 0; nc = 0; pc = 0;
    end else if (det) begin                     // R5, R6
      dc = 0; pc = 0;
      nc = (nc < DMAX) ? nc + 1 : DMAX;
      if (nd != 0 && nc >= nd) begin r = s; nc = 0; end
    end else begin                              // R7, R3, R4, R10
      nc = 0;
      if (pos) begin
        pc = (pc < DMAX) ? pc + 1 : DMAX;
        if (pd != 0 && pc >= pd) begin r = s; pc = 0; snap = 1; end
      end else pc = 0;
      if (snap) dc = 0;
      else if (s > r) begin
        c = (dir == 0) ? ((dc < CMAX) ? dc + 1 : CMAX) : 1;
        dir = 0;
        if (up == 0) dc = 0;
        else if (c >= up) begin r = r + 1; dc = 0; end
        else dc = c;
      end else if (s < r) begin
        c = (dir == 1) ? ((dc < CMAX) ? dc + 1 : CMAX) : 1;
        dir = 1;
        if (dn == 0) dc = 0;
        else if (c >= dn) begin r = r - 1; dc = 0; end
        else dc = c;
      end else dc = 0;
    end
    mref[k] = r; mdc[k] = dc; mnc[k] = nc; mpc[k] = pc; mdir[k] = dir;
    e.key = k; e.rv = r; e.hi = (r > 191); e.lo = (r < 64);
    @(negedge clk);
    expq.push_back(e); tagq.push_back(tag);
    in_valid = 1'b1; in_key = KW'(k); in_sig = SW'(s); in_detect = det;
    in_pos_hi = pos; in_cal = cal; in_up_rate = RW'(up); in_dn_rate = RW'(dn);
    in_neg_dly = DW'(nd); in_pos_dly = DW'(pd);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result: actual key=%0d expected none", out_key);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        if (out_key !== KW'(e.key) || out_ref !== SW'(e.rv) ||
            out_err_hi !== e.hi || out_err_lo !== e.lo) begin
          errors++;
          $display("FAIL %s: actual key=%0d ref=%0d hi=%0b lo=%0b expected key=%0d ref=%0d hi=%0b lo=%0b",
                   t, out_key, out_ref, out_err_hi, out_err_lo, e.key, e.rv, e.hi, e.lo);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual out_valid=%0b expected 0", out_valid);
    end
    // R2 / R8: seeds, including flag edges
    send(0, 128, 0, 0, 1, 0, 0, 0, 0, "R2 seed");
    send(1, 63,  0, 0, 1, 0, 0, 0, 0, "R8 lo edge 63");
    send(2, 192, 0, 0, 1, 0, 0, 0, 0, "R8 hi edge 192");
    send(3, 64,  0, 0, 1, 0, 0, 0, 0, "R8 lo edge 64");
    send(3, 191, 0, 0, 1, 0, 0, 0, 0, "R8 hi edge 191");
    // R3 upward drift, rate 3
    for (int i = 0; i < 7; i++) send(0, 140, 0, 0, 0, 3, 7, 0, 0, "R3 up drift");
    // R4 downward drift, rate 2, independent
    for (int i = 0; i < 6; i++) send(0, 100, 0, 0, 0, 7, 2, 0, 0, "R4 down drift");
    // R3/R4 disabled rates
    for (int i = 0; i < 4; i++) send(0, 200, 0, 0, 0, 0, 1, 0, 0, "R3 up disabled");
    // R10 reversal and equality restart
    send(0, 126, 0, 0, 1, 0, 0, 0, 0, "R2 reseed");
    send(0, 140, 0, 0, 0, 3, 3, 0, 0, "R10 up 1");
    send(0, 140, 0, 0, 0, 3, 3, 0, 0, "R10 up 2");
    send(0, 90,  0, 0, 0, 3, 3, 0, 0, "R10 reverse");
    send(0, 140, 0, 0, 0, 3, 3, 0, 0, "R10 up again 1");
    send(0, 140, 0, 0, 0, 3, 3, 0, 0, "R10 up again 2");
    send(0, 126, 0, 0, 0, 3, 3, 0, 0, "R10 equal");
    send(0, 140, 0, 0, 0, 3, 3, 0, 0, "R10 after equal");
    // R5 no drift while detecting
    for (int i = 0; i < 5; i++) send(0, 60, 1, 0, 0, 1, 1, 0, 0, "R5 detect freeze");
    // R6 negative snap after 5, and interrupted count
    for (int i = 0; i < 3; i++) send(1, 40, 1, 0, 0, 0, 0, 5, 0, "R6 detect pre");
    send(1, 40, 0, 0, 0, 0, 0, 5, 0, "R6 break");
    for (int i = 0; i < 6; i++) send(1, 40, 1, 0, 0, 0, 0, 5, 0, "R6 neg snap");
    // R6 disabled, counter saturates
    for (int i = 0; i < 20; i++) send(2, 30, 1, 0, 0, 0, 0, 0, 0, "R6 disabled saturate");
    send(2, 30, 1, 0, 0, 0, 0, 15, 0, "R6 saturated count snaps");
    // R7 positive snap, interrupted and disabled
    for (int i = 0; i < 2; i++) send(3, 230, 0, 1, 0, 0, 0, 0, 4, "R7 pos pre");
    send(3, 230, 0, 0, 0, 0, 0, 0, 4, "R7 break");
    for (int i = 0; i < 5; i++) send(3, 230, 0, 1, 0, 1, 0, 0, 4, "R7 pos snap");
    for (int i = 0; i < 5; i++) send(1, 250, 0, 1, 0, 0, 0, 0, 0, "R7 disabled");
    idle(3);
    // R9 random interleaving with back-to-back keys
    for (int k = 0; k < NK; k++) send(k, 128, 0, 0, 1, 0, 0, 0, 0, "R9 seed");
    for (int i = 0; i < 1500; i++) begin
      send(int'($urandom_range(NK - 1)), int'($urandom_range(255)),
           ($urandom_range(3) == 0), ($urandom_range(2) == 0),
           ($urandom_range(60) == 0), int'($urandom_range(CMAX)),
           int'($urandom_range(CMAX)), int'($urandom_range(DMAX)),
           int'($urandom_range(DMAX)), "R9 random");
      if ($urandom_range(9) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: actual pending=%0d expected 0", expq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule